// File: doc/BRIEF.md
# Clock-edge coincidence detector

The block watches two free-running clock signals that have no fixed phase relation to each other or to the block's own clock. A faster sampling clock treats both as ordinary data. Each signal first passes through a synchronizer. The last synchronizer stage is then compared with one more delayed copy, so the block can find the rising edge of each signal. When the two rising edges fall within a programmable number of sampling cycles of each other, a single-cycle coincidence pulse is raised. A sticky flag records that at least one coincidence has happened since the last reset or clear.

Exact simultaneity cannot be resolved, so coincidence is defined on the sampling grid. The window input gives the largest allowed distance, in sampling cycles, between the two detection cycles. For every edge to be seen, the sampling clock must run at least twice as fast as the faster monitored clock. No stream moves through the block, so every pin is a plain level or pulse with no handshake, and back-pressure cannot occur.

Top module: `clk_coincidence_detector`

## Requirements
- R1: While `rst_n` is low, `coinc`, `edge_a`, `edge_b` and `first_seen` are all 0.
- R2: Let a monitored input's value be sampled at sampling edge k. Its edge output is high for exactly the one cycle after sampling edge k+1 when sample k is 1 and sample k-1 is 0. In every other cycle it is low, so the block gives one pulse per rising edge and never two in a row.
- R3: The level present when reset is released is not a rising edge. Edge pulses compare only samples taken after release, so the first possible pulse is the cycle after the third sampling edge after release.
- R4: With `win` = 0, a coincidence is detected only in a cycle where `edge_a` and `edge_b` are both high.
- R5: With `win` = W > 0, a coincidence is detected when the cycles of the two edge pulses differ by at most W.
- R6: Each edge pulse takes part in at most one coincidence. After a coincidence, neither input's earlier edge can pair with a later edge of the other input.
- R7: `coinc` is high for exactly one cycle: the cycle after the cycle in which the coincidence was detected.
- R8: `first_seen` becomes 1 on the sampling edge at which `coinc` is high, and it stays 1 until cleared.
- R9: `clr_first` high at a sampling edge clears `first_seen`, and this takes priority over a set on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sampling clock; must be at least twice as fast as the faster monitored clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk_smp` |
| mon_a | input | 1 | First monitored clock, treated as data |
| mon_b | input | 1 | Second monitored clock, treated as data |
| win | input | WIN_W | Coincidence window in sampling cycles; 0 means the same cycle |
| clr_first | input | 1 | Clears the sticky first-match flag |
| coinc | output | 1 | One-cycle coincidence pulse |
| edge_a | output | 1 | Rising-edge pulse of `mon_a`, for debug |
| edge_b | output | 1 | Rising-edge pulse of `mon_b`, for debug |
| first_seen | output | 1 | Sticky flag: a coincidence has occurred since reset or clear |

## Verification
On every cycle, the assertions check local rules. An edge pulse never repeats in the next cycle. A coincidence pulse is never two cycles long and always follows an edge pulse. The sticky flag sets after a pulse, holds, and clears when asked. Whether a pair of edges should have matched depends on the edge history and on the window, so only the bench's scenarios can show it. The bench replays the driven waveforms through a model built on edge distances. The directed cases cover a level held high through reset, a distance of exactly W against W+1, re-use of an already matched edge, and a clear that lands on a coincidence pulse.

// File: rtl/coinc_pkg.sv
`timescale 1ns/1ps
package coinc_pkg;
  // index 0 is input A, index 1 is input B
  localparam int unsigned NUM_MON = 2;
  typedef logic [NUM_MON-1:0] mon_vec_t;
endpackage

// File: rtl/coinc_edge_sampler.sv
`timescale 1ns/1ps
// Synchronizes one monitored clock and flags its rising edges.
module coinc_edge_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon,
  output logic rise
);
  // samples needed before "previous" holds post-reset data
  localparam int unsigned FILL   = SYNC_STAGES + 1;
  localparam int unsigned FW     = $clog2(FILL + 1);
  localparam logic [FW-1:0] FILL_V = FW'(FILL);

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;
  logic [FW-1:0]          fill;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= mon;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], mon};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      fill <= '0;
    end else begin
      prev <= chain[SYNC_STAGES-1];
      if (fill != FILL_V) fill <= fill + 1'b1;
    end
  end

  assign rise = (fill == FILL_V) && chain[SYNC_STAGES-1] && !prev;
endmodule

// File: rtl/coinc_window_match.sv
`timescale 1ns/1ps
// Pairs rising edges of the two inputs that lie within the window.
module coinc_window_match
  import coinc_pkg::*;
#(
  parameter int unsigned WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mon_vec_t         rise,
  input  logic [WIN_W-1:0] win,
  output logic             hit_q
);
  logic [WIN_W-1:0] cnt [NUM_MON];
  mon_vec_t         live;
  logic             hit;

  always_comb begin
    for (int i = 0; i < NUM_MON; i++) live[i] = |cnt[i];
    hit = (rise[0] & rise[1]) | (rise[0] & live[1]) | (rise[1] & live[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      for (int i = 0; i < NUM_MON; i++) cnt[i] <= '0;
    end else begin
      hit_q <= hit;
      for (int i = 0; i < NUM_MON; i++) begin
        if (hit)              cnt[i] <= '0;
        else if (rise[i])     cnt[i] <= win;
        else if (live[i])     cnt[i] <= cnt[i] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/coinc_first_flag.sv
`timescale 1ns/1ps
// Sticky record of the first coincidence; clear wins over set.
module coinc_first_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)         flag <= 1'b0;
    else if (clr)       flag <= 1'b0;
    else if (set_pulse) flag <= 1'b1;
  end
endmodule

// File: rtl/clk_coincidence_detector.sv
`timescale 1ns/1ps
module clk_coincidence_detector
  import coinc_pkg::*;
#(
  parameter int unsigned WIN_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_smp,
  input  logic             rst_n,
  input  logic             mon_a,
  input  logic             mon_b,
  input  logic [WIN_W-1:0] win,
  input  logic             clr_first,
  output logic             coinc,
  output logic             edge_a,
  output logic             edge_b,
  output logic             first_seen
);
  mon_vec_t mon_v;
  mon_vec_t rise_v;

  assign mon_v = {mon_b, mon_a};

  generate
    for (genvar g = 0; g < NUM_MON; g++) begin : g_ch
      coinc_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk  (clk_smp),
        .rst_n(rst_n),
        .mon  (mon_v[g]),
        .rise (rise_v[g])
      );
    end
  endgenerate

  coinc_window_match #(.WIN_W(WIN_W)) u_match (
    .clk  (clk_smp),
    .rst_n(rst_n),
    .rise (rise_v),
    .win  (win),
    .hit_q(coinc)
  );

  coinc_first_flag u_first (
    .clk      (clk_smp),
    .rst_n    (rst_n),
    .set_pulse(coinc),
    .clr      (clr_first),
    .flag     (first_seen)
  );

  assign edge_a = rise_v[0];
  assign edge_b = rise_v[1];
endmodule

// File: rtl/coinc_checker.sv
`timescale 1ns/1ps
module coinc_checker (
  input logic clk_smp,
  input logic rst_n,
  input logic clr_first,
  input logic coinc,
  input logic edge_a,
  input logic edge_b,
  input logic first_seen
);
  a_r2_edge_a_gap: assert property (@(posedge clk_smp) disable iff (!rst_n)
    edge_a |=> !edge_a);
  a_r2_edge_b_gap: assert property (@(posedge clk_smp) disable iff (!rst_n)
    edge_b |=> !edge_b);
  a_r7_single_cycle: assert property (@(posedge clk_smp) disable iff (!rst_n)
    coinc |=> !coinc);
  a_r7_has_cause: assert property (@(posedge clk_smp) disable iff (!rst_n)
    coinc |-> $past(edge_a || edge_b));
  a_r8_sets: assert property (@(posedge clk_smp) disable iff (!rst_n)
    (coinc && !clr_first) |=> first_seen);
  a_r8_holds: assert property (@(posedge clk_smp) disable iff (!rst_n)
    (first_seen && !clr_first) |=> first_seen);
  a_r9_clears: assert property (@(posedge clk_smp) disable iff (!rst_n)
    clr_first |=> !first_seen);
endmodule

bind clk_coincidence_detector coinc_checker u_coinc_checker (
  .clk_smp   (clk_smp),
  .rst_n     (rst_n),
  .clr_first (clr_first),
  .coinc     (coinc),
  .edge_a    (edge_a),
  .edge_b    (edge_b),
  .first_seen(first_seen)
);

// File: tb/test_clk_coincidence_detector.sv
`timescale 1ns/1ps
module test_clk_coincidence_detector;
  localparam int unsigned WIN_W = 4;

  logic clk_smp = 1'b0;
  logic rst_n = 1'b0;
  logic mon_a = 1'b0, mon_b = 1'b0, clr_first = 1'b0;
  logic [WIN_W-1:0] win = '0;
  logic coinc, edge_a, edge_b, first_seen;

  always #2.5 clk_smp = ~clk_smp;

  clk_coincidence_detector #(.WIN_W(WIN_W), .SYNC_STAGES(2)) i_clk_coincidence_detector (
    .clk_smp(clk_smp), .rst_n(rst_n), .mon_a(mon_a), .mon_b(mon_b), .win(win),
    .clr_first(clr_first), .coinc(coinc), .edge_a(edge_a), .edge_b(edge_b),
    .first_seen(first_seen)
  );

  int checks = 0, errors = 0, n = 0, win_v = 0, ra = 0, rb = 0;
  int hpa = 0, hpb = 0;
  bit ha0, ha1, ha2, hb0, hb1, hb2, cur_a, cur_b;
  bit a_pend, b_pend, exp_coinc, exp_first, last_clr, done;

  task automatic chk(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at sample %0d", tag, act, exp, n);
    end
  endtask

  // checks state after the latest sampling edge, advances the model, drives next inputs
  task automatic tick(input bit a, input bit b, input bit c);
    bit ea, eb, hit;
    @(negedge clk_smp);
    n++;
    ha2 = ha1; ha1 = ha0; ha0 = cur_a;
    hb2 = hb1; hb1 = hb0; hb0 = cur_b;
    ea = (n >= 3) && ha1 && !ha2;
    eb = (n >= 3) && hb1 && !hb2;
    chk((n <= 3) ? "R3" : "R2", edge_a, ea);
    chk((n <= 3) ? "R3" : "R2", edge_b, eb);
    chk((win_v == 0) ? "R4" : "R5", coinc, exp_coinc);   // also R6, R7 timing
    chk(last_clr ? "R9" : "R8", first_seen, exp_first);
    hit = (ea && eb) || (ea && b_pend && (n - rb) <= win_v)
                     || (eb && a_pend && (n - ra) <= win_v);
    if (hit) begin
      a_pend = 0; b_pend = 0;
    end else begin
      if (ea) begin a_pend = 1; ra = n; end
      if (eb) begin b_pend = 1; rb = n; end
    end
    exp_first = c ? 1'b0 : (exp_coinc ? 1'b1 : exp_first);
    exp_coinc = hit;
    last_clr = c;
    cur_a = a; cur_b = b;
    mon_a = a; mon_b = b; clr_first = c;
  endtask

  task automatic do_reset(input bit a, input bit b);
    rst_n = 1'b0; clr_first = 1'b0;
    mon_a = a; mon_b = b; cur_a = a; cur_b = b;
    repeat (3) @(negedge clk_smp);
    chk("R1", coinc, 1'b0);
    chk("R1", edge_a, 1'b0);
    chk("R1", edge_b, 1'b0);
    chk("R1", first_seen, 1'b0);
    rst_n = 1'b1;
    n = 0; a_pend = 0; b_pend = 0; exp_coinc = 0; exp_first = 0; last_clr = 0;
    ha0 = 0; ha1 = 0; ha2 = 0; hb0 = 0; hb1 = 0; hb2 = 0;
  endtask

  task automatic quiet(input int k);
    for (int i = 0; i < k; i++) tick(1'b0, 1'b0, 1'b0);
  endtask

  task automatic set_win(input int w);
    quiet(12);                      // let every open window expire first
    win = WIN_W'(w); win_v = w;
  endtask

  task automatic rand_run(input int k);
    bit na, nb, c;
    for (int i = 0; i < k; i++) begin
      if (hpa == 0) begin na = !cur_a; hpa = $urandom_range(6, 0); end
      else begin na = cur_a; hpa--; end
      if (hpb == 0) begin nb = !cur_b; hpb = $urandom_range(6, 0); end
      else begin nb = cur_b; hpb--; end
      c = ($urandom_range(15, 0) == 0);
      tick(na, nb, c);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk_smp);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2: run incomplete, got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    // R1, R3: both inputs high through reset release, no edge may appear
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b1, 1'b0);
    quiet(4);
    // R4: same-cycle rise matches, one cycle apart does not
    tick(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b0);
    quiet(3);
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b0);
    quiet(4);
    // R5: distance 3 with window 3 matches, distance 4 does not
    set_win(3);
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b0);
    quiet(6);
    tick(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b0);
    quiet(8);
    // R6: a matched edge of B cannot pair with A's next rise
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    tick(1'b1, 1'b1, 1'b0);
    quiet(8);
    // R7, R9: clear lands on the coincidence pulse, clear must win
    tick(1'b1, 1'b1, 1'b0);
    tick(1'b1, 1'b1, 1'b0);
    tick(1'b1, 1'b1, 1'b0);
    tick(1'b1, 1'b1, 1'b1);
    tick(1'b1, 1'b1, 1'b0);
    quiet(6);
    // random phases over several windows
    set_win(0); rand_run(700);
    set_win(1); rand_run(700);
    set_win(2); rand_run(700);
    set_win(5); rand_run(700);
    quiet(8);
    done = 1;
    summary();
    $finish;
  end
endmodule